// File: doc/BRIEF.md
# MDIO Station Management Master

This block lets a host read and write registers in an external Ethernet PHY over the two-wire management interface. The host programs three small registers through a simple write strobe and a combinational read port: a command register, a data register and a clock divider. It produces the MDC clock from the system clock, shifts out a clause-22 management frame on MDIO and, for reads, captures the PHY's reply.

A single bit in the command register is both the start command and the completion flag. Setting it launches a frame, and the block clears it when the last bit time has ended. While that flag is set the register bank is frozen. Software therefore polls the flag before it issues the next request.

Top module: `mdio_master`

## Requirements
- R1: Writing the command register (select 0) with bit 15 set starts a frame. Bit 15 then reads back 1 until the 64th bit time has ended, and reads back 0 after that.
- R2: Command register layout: bits 4:0 hold the register address, bits 9:5 the PHY address, and bit 10 the direction (1 = write, 0 = read). These fields read back as written, and bits 14:11 read as 0.
- R3: A write frame drives MDIO for all 64 bits, MSB first at each MDC rising edge, in this order: 32 ones, `01`, `01`, PHY address, register address, `10`, then the 16 bits of the data register (select 1). The data register is left unchanged.
- R4: A read frame uses opcode `10` and drives MDIO for the first 46 bits. It then releases MDIO (output enable low) for the two turnaround bits and the 16 data bits. It samples MDIO at each of the last 16 rising MDC edges, MSB first, and the data register holds the result once busy is clear.
- R5: The MDC period is 2 × (div + 1) system clocks. The high and low halves are equal, and div is the field at select 2. It resets to 39, which gives 2.5 MHz from a 200 MHz clock.
- R6: While busy is set, every register write is ignored: command fields, busy, data and divider all keep their values, and no second frame begins.
- R7: Each frame has exactly 64 rising MDC edges. Outside a frame, MDC is held low and MDIO is released.
- R8: After reset, busy is 0, the data register is 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 divider |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A wrong bit counter or frame shifter shows up as a wrong MDIO level at a specific rising MDC edge. The bench records every edge, so the fault is located to the bit time within one frame. A fault in the direction logic shows as the output enable held high into the turnaround, or as a data register holding shifted-wrong bits once busy drops. A divider fault shows at the first two MDC edges as a wrong period. Leaked writes while busy show up in the register read-back of the same transaction, or as extra MDC edges after the frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(32);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(46);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(48);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);

  logic             busy_q, op_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      data_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             mdc_q;
  logic [IDX_W-1:0] bit_q;
  logic [31:0]      sh_q;

  wire wr_ok = reg_wr && !busy_q;
  wire start = wr_ok && reg_sel == 2'd0 && reg_wdata[15];
  wire half_done = cnt_q == div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_sel)
          2'd0: begin
            busy_q <= reg_wdata[15];
            op_q   <= reg_wdata[10];
            phy_q  <= reg_wdata[9:5];
            reg_q  <= reg_wdata[4:0];
          end
          2'd1: data_q <= reg_wdata;
          2'd2: div_q  <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (start) begin
        cnt_q <= '0;
        mdc_q <= 1'b0;
        bit_q <= '0;
        sh_q  <= {2'b01, reg_wdata[10] ? 2'b01 : 2'b10, reg_wdata[9:5], reg_wdata[4:0],
                  reg_wdata[10] ? 2'b10 : 2'b00, reg_wdata[10] ? data_q : 16'h0000};
      end else if (busy_q) begin
        if (!half_done) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (!op_q && bit_q >= DATA_POS)
              data_q <= {data_q[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (bit_q == LAST_BIT) busy_q <= 1'b0;
            else bit_q <= bit_q + 1'b1;
            if (bit_q >= PRE_END) sh_q <= {sh_q[30:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = busy_q && (bit_q < PRE_END ? 1'b1 : sh_q[31]);
  assign mdio_oe = busy_q && (op_q || bit_q < TA_POS);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {busy_q, 4'b0000, op_q, phy_q, reg_q};
      2'd1:    reg_rdata = data_q;
      2'd2:    reg_rdata = {{(16-DIV_W){1'b0}}, div_q};
      default: reg_rdata = 16'h0000;
    endcase
  end

  a_r1_clears_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bit_q) == LAST_BIT && $past(mdc_q));
  a_r3_preamble_driven: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && bit_q < PRE_END |-> mdio_oe && mdio_o);
  a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !op_q && bit_q >= TA_POS |-> !mdio_oe);
  a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $rose(mdc) |-> $past(cnt_q) == $past(div_q));
  a_r6_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && reg_wr |=> phy_q == $past(phy_q) && reg_q == $past(reg_q)
                          && op_q == $past(op_q) && div_q == $past(div_q));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc && !mdio_oe);
endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_tests = 0, n_fail = 0;
  int edge_n = 0;
  logic cap_o [64];
  logic cap_oe [64];
  realtime t_e0, t_e1;
  logic [15:0] resp = 16'h0;

  always #2.5 clk = ~clk;

  mdio_master dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    if (edge_n == 0) t_e0 = $realtime;
    if (edge_n == 1) t_e1 = $realtime;
    #1;
    if (edge_n < 64) begin
      cap_o[edge_n] = mdio_o;
      cap_oe[edge_n] = mdio_oe;
    end
    edge_n = edge_n + 1;
    if (edge_n >= 48 && edge_n < 64) mdio_i = resp[63 - edge_n];
    else mdio_i = 1'b1;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    #0.5 v = reg_rdata;
  endtask

  function automatic logic exp_bit(int k, logic op, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    logic [31:0] f;
    f = {2'b01, op ? 2'b01 : 2'b10, phy, ra, op ? 2'b10 : 2'b00, op ? d : 16'h0};
    return (k < 32) ? 1'b1 : f[63 - k];
  endfunction

  function automatic logic exp_oe(int k, logic op);
    return op || k < 46;
  endfunction

  task automatic run(input logic op, input logic [4:0] phy, input logic [4:0] ra,
                     input logic [15:0] d, input logic [7:0] dv, input bit meddle);
    logic [15:0] v;
    logic [15:0] exp_data;
    int bad_o, bad_oe, guard;
    wr(2'd2, {8'h0, dv});
    wr(2'd1, d);
    resp = 16'($urandom);
    edge_n = 0;
    wr(2'd0, {1'b1, 4'b0, op, phy, ra});
    rd(2'd0, v);
    check("R1 busy set after start", 32'(v[15]), 32'd1);
    if (meddle) begin
      wr(2'd0, {1'b1, 4'b0, ~op, ~phy, ~ra});
      wr(2'd1, ~d);
      wr(2'd2, 16'h0005);
    end
    guard = 0;
    do begin rd(2'd0, v); guard++; end while (v[15] && guard < 5000);
    check("R1 busy clears", 32'(v[15]), 32'd0);
    check("R2 command fields", 32'(v), 32'({1'b0, 4'b0, op, phy, ra}));
    repeat (4 * (dv + 1) + 4) @(negedge clk);
    check("R7 edges per frame", 32'(edge_n), 32'd64);
    check("R7 idle mdc/oe", 32'({mdc, mdio_oe}), 32'd0);
    bad_o = 0; bad_oe = 0;
    for (int k = 0; k < 64; k++) begin
      if (cap_oe[k] !== exp_oe(k, op)) bad_oe++;
      if (exp_oe(k, op) && cap_o[k] !== exp_bit(k, op, phy, ra, d)) bad_o++;
    end
    check(op ? "R3 write frame bits" : "R4 read frame bits", 32'(bad_o), 32'd0);
    check(op ? "R3 drive enable" : "R4 turnaround release", 32'(bad_oe), 32'd0);
    n_tests++;
    if ($rtoi(t_e1 - t_e0 + 0.5) != 10 * (dv + 1)) begin
      n_fail++;
      $display("FAIL R5 mdc period: actual=%0d expected=%0d", $rtoi(t_e1 - t_e0 + 0.5), 10 * (dv + 1));
    end
    exp_data = op ? d : resp;
    rd(2'd1, v);
    check(op ? "R3 data kept" : "R4 read data", 32'(v), 32'(exp_data));
    rd(2'd2, v);
    check(meddle ? "R6 divider frozen" : "R5 divider readback", 32'(v), 32'(dv));
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 mdc/oe in reset", 32'({mdc, mdio_oe}), 32'd0);
    rst_n = 1'b1;
    rd(2'd0, v); check("R8 busy after reset", 32'(v[15]), 32'd0);
    rd(2'd1, v); check("R8 data after reset", 32'(v), 32'd0);
    rd(2'd2, v); check("R5 divider reset 39", 32'(v), 32'd39);
    repeat (20) @(negedge clk);
    check("R7 no mdc when idle", 32'(edge_n), 32'd0);
    run(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 8'd0, 1'b0);
    run(1'b0, 5'h00, 5'h00, 16'h0000, 8'd0, 1'b0);
    run(1'b1, 5'h15, 5'h0A, 16'hA55A, 8'd2, 1'b1);
    run(1'b0, 5'h0C, 5'h13, 16'h1234, 8'd1, 1'b1);
    for (int i = 0; i < 10; i++)
      run(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 8'($urandom_range(0, 3)), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule